// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds the time of day and the calendar date in packed BCD registers: seconds, minutes, hours, weekday, day of month, month and a two-digit year, with a century flag kept in the top bit of the month register. A base-rate enable (`tick_en`) feeds an internal prescaler. Every `TICKS_PER_SEC` enabled cycles, the prescaler produces one-second steps. The hour register counts either as a 24-hour clock or as a 12-hour clock with an afternoon flag, selected by a static mode input.

Carries ripple through the fields one per clock cycle, from minutes up to the year. While a ripple is in flight, `holdoff_o` is high. A reader that samples the fields only while `holdoff_o` is low therefore never sees a half-updated date. A host write port loads every field in one cycle. The write also restarts the prescaler from zero and cancels any ripple still in flight.

Top module: `bcd_calendar`

## Requirements
- R1: During and after reset the fields read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x00, day 0x01, month 0x01 (century bit 7 clear), year 0x00, and `holdoff_o` is low.
- R2: Seconds advance by one BCD step on the `TICKS_PER_SEC`-th cycle with `tick_en` high after a load or a previous step. Cycles with `tick_en` low leave every field unchanged.
- R3: Seconds and minutes count in BCD from 0x00 to 0x59. Seconds 0x59 wraps to 0x00 and carries into minutes, and minutes 0x59 wraps to 0x00 and carries into hours.
- R4: With `mode_24h` high, hours count 0x00 to 0x23, and 0x23 wraps to 0x00 with a carry into the day.
- R5: With `mode_24h` low, hours bits 4:0 hold the BCD hour 1 to 12 and bit 5 is the afternoon flag. The sequence is 0x11 to 0x32 (noon) with no day carry, 0x32 to 0x21, 0x31 to 0x12 (midnight) with a day carry, and 0x12 to 0x01.
- R6: Day of month runs from 0x01 up to the month length and then wraps to 0x01 with a month carry. Months 04, 06, 09 and 11 have 30 days, February has 28, or 29 when the two-digit year is divisible by four (year 00 included), and the other months have 31.
- R7: Month (bits 4:0) counts 0x01 to 0x12 and wraps to 0x01 with a year carry. Year counts 0x00 to 0x99, and the wrap from 0x99 to 0x00 toggles month bit 7.
- R8: Weekday (bits 2:0) increments with every day carry and wraps from 6 to 0.
- R9: A cycle with `load_en` high writes all fields on that edge with masks seconds 0x7F, minutes 0x7F, hours 0x3F, weekday 0x07, day 0x3F, month 0x9F, year 0xFF. It restarts the prescaler from zero and cancels a ripple in flight, so `holdoff_o` is low on the next cycle. A load takes precedence over a simultaneous `tick_en`.
- R10: After a seconds step that wraps, `holdoff_o` rises in the cycle the new seconds value appears. It stays high while higher fields update, one per cycle, and falls once the last affected field has settled. A full ripple to the year keeps it high for five cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Base-rate enable counted by the prescaler |
| mode_24h | input | 1 | 1 = 24-hour counting, 0 = 12-hour counting with afternoon flag |
| load_en | input | 1 | Host write strobe for all fields |
| ld_sec | input | 8 | Seconds value to load (BCD) |
| ld_min | input | 8 | Minutes value to load (BCD) |
| ld_hour | input | 8 | Hours value to load (BCD, bit 5 afternoon flag in 12-hour mode) |
| ld_wday | input | 8 | Weekday value to load |
| ld_day | input | 8 | Day of month to load (BCD) |
| ld_month | input | 8 | Month to load (BCD in bits 4:0, century flag in bit 7) |
| ld_year | input | 8 | Two-digit year to load (BCD) |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| wday_o | output | 8 | Weekday |
| day_o | output | 8 | Day of month |
| month_o | output | 8 | Month with century flag |
| year_o | output | 8 | Two-digit year |
| holdoff_o | output | 1 | High while a carry ripple is in flight |

## Verification
The bench targets the 12-hour turnovers. If the afternoon flag were toggled at 12 rather than at 11, noon would read 0x12 and midnight would fail to carry into the day. It also covers month ends: 30-day months, February in a leap year, a non-leap year and year 00, and the December and year-99 wraps. A wrong length table shows up as a 31st of April or a missing 29th of February, and a century fault shows as an unchanged month bit 7. Directed tests count prescaler cycles exactly around a reload, watch `holdoff_o` cycle by cycle through a full ripple, and reload in the middle of a ripple. A design that lets a stale carry finish after the reload would overwrite the freshly loaded hour.

// File: rtl/cal_pkg.sv
package cal_pkg;

   // carry ripple position: which field updates on the next edge
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_MIN  = 3'd1,
      ST_HOUR = 3'd2,
      ST_DAY  = 3'd3,
      ST_MON  = 3'd4,
      ST_YEAR = 3'd5
   } ripple_stage_e;

   localparam int unsigned FIELD_W = 8;

   // bits kept on a host write
   localparam logic [FIELD_W-1:0] SEC_KEEP  = 8'h7F;
   localparam logic [FIELD_W-1:0] MIN_KEEP  = 8'h7F;
   localparam logic [FIELD_W-1:0] HOUR_KEEP = 8'h3F;
   localparam logic [FIELD_W-1:0] WDAY_KEEP = 8'h07;
   localparam logic [FIELD_W-1:0] DAY_KEEP  = 8'h3F;
   localparam logic [FIELD_W-1:0] MON_KEEP  = 8'h9F;
   localparam logic [FIELD_W-1:0] YEAR_KEEP = 8'hFF;

   localparam int unsigned CENTURY_BIT = 7;
   localparam int unsigned PM_BIT      = 5;

   // two-digit BCD year divisible by four: (10*t + o) mod 4 == (2*t + o) mod 4
   function automatic logic leap_year(input logic [7:0] yr);
      logic [5:0] s;
      s = {1'b0, yr[7:4], 1'b0} + {2'b00, yr[3:0]};
      return (s[1:0] == 2'b00);
   endfunction

   // last day of a BCD month, itself in BCD
   function automatic logic [7:0] month_len(input logic [4:0] mon, input logic leap);
      logic [7:0] r;
      case (mon)
         5'h02:                      r = leap ? 8'h29 : 8'h28;
         5'h04, 5'h06, 5'h09, 5'h11: r = 8'h30;
         default:                    r = 8'h31;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
   parameter int unsigned DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic clr_i,
   output logic stb_o
);
   localparam int unsigned CW      = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit          IS_POW2 = ((DIV & (DIV - 1)) == 0);
   localparam logic [CW-1:0] LAST  = CW'(DIV - 1);

   initial begin
      if (DIV < 2) $fatal(1, "cal_prescaler: DIV must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   generate
      if (IS_POW2) begin : g_pow2
         // free-running counter wraps on its own width
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (clr_i)  cnt_q <= '0;
            else if (tick_i) cnt_q <= cnt_q + 1'b1;
         end
         assign stb_o = tick_i && !clr_i && (&cnt_q);
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (clr_i)  cnt_q <= '0;
            else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
         assign stb_o = tick_i && !clr_i && (cnt_q == LAST);
      end
   endgenerate

   // R9: a host write restarts the prescaler
   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/cal_bcd_step.sv
module cal_bcd_step #(
   parameter int unsigned DIGITS = 2
) (
   input  logic [4*DIGITS-1:0] cur_i,
   input  logic [4*DIGITS-1:0] lo_i,
   input  logic [4*DIGITS-1:0] hi_i,
   output logic [4*DIGITS-1:0] nxt_o,
   output logic                wrap_o
);
   localparam int unsigned W = 4 * DIGITS;

   initial begin
      if (DIGITS < 1) $fatal(1, "cal_bcd_step: DIGITS must be at least 1");
   end

   logic [DIGITS-1:0] cy;
   logic [W-1:0]      inc;

   assign cy[0] = 1'b1;

   generate
      for (genvar d = 0; d < DIGITS; d++) begin : g_dig
         logic [3:0] dig;
         assign dig          = cur_i[4*d +: 4];
         assign inc[4*d +: 4] = cy[d] ? ((dig == 4'd9) ? 4'd0 : dig + 4'd1) : dig;
         if (d + 1 < DIGITS) begin : g_cy
            assign cy[d+1] = cy[d] && (dig == 4'd9);
         end
      end
   endgenerate

   // at or above the limit (including out-of-range loads) restart at the floor
   assign wrap_o = (cur_i >= hi_i);
   assign nxt_o  = wrap_o ? lo_i : inc;

endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step
   import cal_pkg::*;
(
   input  logic [7:0] hour_i,
   input  logic       mode_24h_i,
   output logic [7:0] nxt_o,
   output logic       day_cy_o
);
   logic [7:0] nx24, nx12;
   logic       wr24, wr12;
   logic       pm;
   logic       unused_hour;

   assign pm = hour_i[PM_BIT];

   cal_bcd_step #(.DIGITS(2)) u_step24 (
      .cur_i (hour_i),
      .lo_i  (8'h00),
      .hi_i  (8'h23),
      .nxt_o (nx24),
      .wrap_o(wr24)
   );

   cal_bcd_step #(.DIGITS(2)) u_step12 (
      .cur_i ({3'b000, hour_i[4:0]}),
      .lo_i  (8'h01),
      .hi_i  (8'h12),
      .nxt_o (nx12),
      .wrap_o(wr12)
   );

   assign unused_hour = ^{nx12[7:5], wr12};

   always_comb begin
      if (mode_24h_i) begin
         nxt_o    = nx24;
         day_cy_o = wr24;
      end else if (hour_i[4:0] == 5'h11) begin
         // 11 -> 12 flips the half of the day; only the evening one ends the day
         nxt_o    = {2'b00, ~pm, 5'h12};
         day_cy_o = pm;
      end else begin
         nxt_o    = {2'b00, pm, nx12[4:0]};
         day_cy_o = 1'b0;
      end
   end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
   import cal_pkg::*;
#(
   parameter int unsigned TICKS_PER_SEC = 32768,
   parameter int unsigned WDAY_LAST     = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       mode_24h,
   input  logic       load_en,
   input  logic [7:0] ld_sec,
   input  logic [7:0] ld_min,
   input  logic [7:0] ld_hour,
   input  logic [7:0] ld_wday,
   input  logic [7:0] ld_day,
   input  logic [7:0] ld_month,
   input  logic [7:0] ld_year,
   output logic [7:0] sec_o,
   output logic [7:0] min_o,
   output logic [7:0] hour_o,
   output logic [7:0] wday_o,
   output logic [7:0] day_o,
   output logic [7:0] month_o,
   output logic [7:0] year_o,
   output logic       holdoff_o
);
   // a full ripple takes five cycles after the seconds step; it must end before the next step
   localparam int unsigned RIPPLE_CYCLES = 5;
   localparam logic [7:0]  WDAY_TOP      = 8'(WDAY_LAST);

   initial begin
      if (TICKS_PER_SEC < RIPPLE_CYCLES + 3)
         $fatal(1, "bcd_calendar: TICKS_PER_SEC too small for the carry ripple");
      if (WDAY_LAST < 1 || WDAY_LAST > 7)
         $fatal(1, "bcd_calendar: WDAY_LAST must fit the 3-bit weekday field");
   end

   logic [7:0] sec_q, min_q, hour_q, wday_q, day_q, mon_q, year_q;
   ripple_stage_e stage_q;
   logic sec_stb;

   cal_prescaler #(.DIV(TICKS_PER_SEC)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .tick_i(tick_en),
      .clr_i (load_en),
      .stb_o (sec_stb)
   );

   logic [7:0] sec_nx, min_nx, hour_nx, day_nx, mon_nx, year_nx, wday_nx;
   logic       sec_wr, min_wr, day_cy, day_wr, mon_wr, year_wr;
   logic [7:0] day_top;
   logic       unused_mon;

   cal_bcd_step #(.DIGITS(2)) u_sec (
      .cur_i(sec_q), .lo_i(8'h00), .hi_i(8'h59), .nxt_o(sec_nx), .wrap_o(sec_wr));

   cal_bcd_step #(.DIGITS(2)) u_min (
      .cur_i(min_q), .lo_i(8'h00), .hi_i(8'h59), .nxt_o(min_nx), .wrap_o(min_wr));

   cal_hour_step u_hour (
      .hour_i(hour_q), .mode_24h_i(mode_24h), .nxt_o(hour_nx), .day_cy_o(day_cy));

   assign day_top = month_len(mon_q[4:0], leap_year(year_q));

   cal_bcd_step #(.DIGITS(2)) u_day (
      .cur_i(day_q), .lo_i(8'h01), .hi_i(day_top), .nxt_o(day_nx), .wrap_o(day_wr));

   cal_bcd_step #(.DIGITS(2)) u_mon (
      .cur_i({3'b000, mon_q[4:0]}), .lo_i(8'h01), .hi_i(8'h12),
      .nxt_o(mon_nx), .wrap_o(mon_wr));

   cal_bcd_step #(.DIGITS(2)) u_year (
      .cur_i(year_q), .lo_i(8'h00), .hi_i(8'h99), .nxt_o(year_nx), .wrap_o(year_wr));

   assign unused_mon = ^mon_nx[7:5];
   assign wday_nx    = (wday_q >= WDAY_TOP) ? 8'h00 : wday_q + 8'h01;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q   <= 8'h00;
         min_q   <= 8'h00;
         hour_q  <= 8'h00;
         wday_q  <= 8'h00;
         day_q   <= 8'h01;
         mon_q   <= 8'h01;
         year_q  <= 8'h00;
         stage_q <= ST_IDLE;
      end else if (load_en) begin
         sec_q   <= ld_sec   & SEC_KEEP;
         min_q   <= ld_min   & MIN_KEEP;
         hour_q  <= ld_hour  & HOUR_KEEP;
         wday_q  <= ld_wday  & WDAY_KEEP;
         day_q   <= ld_day   & DAY_KEEP;
         mon_q   <= ld_month & MON_KEEP;
         year_q  <= ld_year  & YEAR_KEEP;
         stage_q <= ST_IDLE;
      end else begin
         unique case (stage_q)
            ST_IDLE: if (sec_stb) begin
               sec_q <= sec_nx;
               if (sec_wr) stage_q <= ST_MIN;
            end
            ST_MIN: begin
               min_q   <= min_nx;
               stage_q <= min_wr ? ST_HOUR : ST_IDLE;
            end
            ST_HOUR: begin
               hour_q  <= hour_nx;
               stage_q <= day_cy ? ST_DAY : ST_IDLE;
            end
            ST_DAY: begin
               wday_q  <= wday_nx;
               day_q   <= day_nx;
               stage_q <= day_wr ? ST_MON : ST_IDLE;
            end
            ST_MON: begin
               mon_q   <= {mon_q[CENTURY_BIT], 2'b00, mon_nx[4:0]};
               stage_q <= mon_wr ? ST_YEAR : ST_IDLE;
            end
            ST_YEAR: begin
               year_q  <= year_nx;
               if (year_wr) mon_q[CENTURY_BIT] <= ~mon_q[CENTURY_BIT];
               stage_q <= ST_IDLE;
            end
            default: stage_q <= ST_IDLE;
         endcase
      end
   end

   assign sec_o     = sec_q;
   assign min_o     = min_q;
   assign hour_o    = hour_q;
   assign wday_o    = wday_q;
   assign day_o     = day_q;
   assign month_o   = mon_q;
   assign year_o    = year_q;
   assign holdoff_o = (stage_q != ST_IDLE);

   // R2: seconds move only on a prescaler step or a host write
   p_quiet_sec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_stb && !load_en) |=> $stable(sec_q));

   // R10: no seconds step lands while a ripple is in flight
   p_ripple_no_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (holdoff_o && !load_en) |=> $stable(sec_q));

   // R4: 23 wraps to 00 and hands a carry to the day
   p_day_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q == ST_HOUR && mode_24h && hour_q == 8'h23 && !load_en)
      |=> (hour_q == 8'h00 && stage_q == ST_DAY));

   // R5: 11 in the evening becomes 12 in the morning with a day carry
   p_midnight12_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q == ST_HOUR && !mode_24h && hour_q == 8'h31 && !load_en)
      |=> (hour_q == 8'h12 && stage_q == ST_DAY));

   // R7: year 99 -> 00 flips the century flag
   p_century_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q == ST_YEAR && year_q == 8'h99 && !load_en)
      |=> (year_q == 8'h00 && mon_q[CENTURY_BIT] != $past(mon_q[CENTURY_BIT])));

   // R8: weekday wraps from its last value to zero
   p_wday_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q == ST_DAY && wday_q == WDAY_TOP && !load_en) |=> (wday_q == 8'h00));

   // R9: a host write cancels the ripple
   p_load_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> !holdoff_o);

endmodule

// File: tb/bcd_calendar_tb_top.sv
module bcd_calendar_tb_top;
   localparam int unsigned TPS = 8;
   localparam int unsigned NV  = 18;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_en = 1'b0, mode_24h = 1'b1, load_en = 1'b0;
   logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_wday = 0, ld_day = 0, ld_month = 0, ld_year = 0;
   logic [7:0] sec_o, min_o, hour_o, wday_o, day_o, month_o, year_o;
   logic holdoff_o;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   bcd_calendar #(.TICKS_PER_SEC(TPS)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_24h(mode_24h), .load_en(load_en),
      .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_wday(ld_wday),
      .ld_day(ld_day), .ld_month(ld_month), .ld_year(ld_year),
      .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
      .day_o(day_o), .month_o(month_o), .year_o(year_o), .holdoff_o(holdoff_o));

   // {mode_24h, start: sec min hour wday day month year, expected after one second: same order}
   localparam logic [112:0] VEC [NV] = '{
      {1'b1, 56'h30_20_10_02_15_05_24, 56'h31_20_10_02_15_05_24},
      {1'b1, 56'h59_20_10_02_15_05_24, 56'h00_21_10_02_15_05_24},
      {1'b1, 56'h59_59_10_02_15_05_24, 56'h00_00_11_02_15_05_24},
      {1'b1, 56'h59_59_23_03_15_05_24, 56'h00_00_00_04_16_05_24},
      {1'b0, 56'h59_59_11_01_10_06_24, 56'h00_00_32_01_10_06_24},
      {1'b0, 56'h59_59_32_01_10_06_24, 56'h00_00_21_01_10_06_24},
      {1'b0, 56'h59_59_31_06_09_06_24, 56'h00_00_12_00_10_06_24},
      {1'b0, 56'h59_59_12_01_10_06_24, 56'h00_00_01_01_10_06_24},
      {1'b1, 56'h59_59_23_02_30_04_24, 56'h00_00_00_03_01_05_24},
      {1'b1, 56'h59_59_23_02_30_01_24, 56'h00_00_00_03_31_01_24},
      {1'b1, 56'h59_59_23_02_28_02_23, 56'h00_00_00_03_01_03_23},
      {1'b1, 56'h59_59_23_02_28_02_24, 56'h00_00_00_03_29_02_24},
      {1'b1, 56'h59_59_23_02_29_02_24, 56'h00_00_00_03_01_03_24},
      {1'b1, 56'h59_59_23_05_31_12_23, 56'h00_00_00_06_01_01_24},
      {1'b1, 56'h59_59_23_06_31_12_99, 56'h00_00_00_00_01_81_00},
      {1'b1, 56'h59_59_23_06_31_92_99, 56'h00_00_00_00_01_01_00},
      {1'b1, 56'h59_59_23_02_28_02_00, 56'h00_00_00_03_29_02_00},
      {1'b1, 56'h59_59_23_02_30_11_24, 56'h00_00_00_03_01_12_24}
   };

   function automatic string vec_req(input int i);
      case (i)
         0:                  return "R2";
         1, 2:               return "R3";
         3:                  return "R4/R8";
         4, 5, 7:            return "R5";
         6:                  return "R5/R8";
         13, 14, 15:         return "R7";
         default:            return "R6";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req, input logic [55:0] e, input logic hold);
      chk(req, "sec",     sec_o,   e[55:48]);
      chk(req, "min",     min_o,   e[47:40]);
      chk(req, "hour",    hour_o,  e[39:32]);
      chk(req, "wday",    wday_o,  e[31:24]);
      chk(req, "day",     day_o,   e[23:16]);
      chk(req, "month",   month_o, e[15:8]);
      chk(req, "year",    year_o,  e[7:0]);
      chk(req, "holdoff", {7'd0, holdoff_o}, {7'd0, hold});
   endtask

   // called at a falling edge; the load happens on the next rising edge
   task automatic do_load(input logic m24, input logic [55:0] f, input logic tick_during);
      mode_24h = m24;
      {ld_sec, ld_min, ld_hour, ld_wday, ld_day, ld_month, ld_year} = f;
      load_en  = 1'b1;
      tick_en  = tick_during;
      @(negedge clk);
      load_en  = 1'b0;
      tick_en  = 1'b0;
   endtask

   task automatic run_ticks(input int n);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         checks++;
         failures++;
         $display("FAIL R10 watchdog expired actual=%0d expected<%0d cycles", cyc, 100000);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1: reset state, also while reset is held
      idle(3);
      chk_all("R1", 56'h00_00_00_00_01_01_00, 1'b0);
      rst_n = 1'b1;
      idle(2);
      chk_all("R1", 56'h00_00_00_00_01_01_00, 1'b0);

      // table walk: one second from each starting point, then let the ripple settle
      for (int i = 0; i < NV; i++) begin
         do_load(VEC[i][112], VEC[i][111:56], 1'b0);
         run_ticks(TPS);
         idle(6);
         chk_all(vec_req(i), VEC[i][55:0], 1'b0);
      end

      // R9: write masks
      do_load(1'b1, 56'hFF_FF_FF_FF_FF_FF_FF, 1'b0);
      chk_all("R9", 56'h7F_7F_3F_07_3F_9F_FF, 1'b0);

      // R2: exact prescaler count, and tick_en low holds everything
      do_load(1'b1, 56'h10_00_08_01_05_03_24, 1'b0);
      run_ticks(TPS - 1);
      chk("R2", "sec before last tick", sec_o, 8'h10);
      run_ticks(1);
      chk("R2", "sec on last tick", sec_o, 8'h11);
      idle(20);
      chk_all("R2", 56'h11_00_08_01_05_03_24, 1'b0);

      // R9: a write with tick_en high restarts the prescaler
      do_load(1'b1, 56'h20_00_08_01_05_03_24, 1'b0);
      run_ticks(5);
      do_load(1'b1, 56'h20_00_08_01_05_03_24, 1'b1);
      run_ticks(TPS - 1);
      chk("R9", "sec after restart, one tick short", sec_o, 8'h20);
      run_ticks(1);
      chk("R9", "sec after restart, full count", sec_o, 8'h21);

      // R10: holdoff through a full ripple
      do_load(1'b1, 56'h59_59_23_06_31_12_99, 1'b0);
      run_ticks(TPS);
      chk("R10", "holdoff after seconds wrap", {7'd0, holdoff_o}, 8'h01);
      chk("R10", "sec after wrap", sec_o, 8'h00);
      chk("R10", "min not yet updated", min_o, 8'h59);
      idle(4);
      chk("R10", "holdoff before year update", {7'd0, holdoff_o}, 8'h01);
      chk("R10", "year not yet updated", year_o, 8'h99);
      idle(1);
      chk("R10", "holdoff after year update", {7'd0, holdoff_o}, 8'h00);
      chk_all("R10", 56'h00_00_00_00_01_81_00, 1'b0);

      // R9: a write in mid-ripple cancels the remaining carries
      do_load(1'b1, 56'h59_59_23_06_31_12_99, 1'b0);
      run_ticks(TPS);
      idle(1);
      chk("R9", "min updated mid-ripple", min_o, 8'h00);
      do_load(1'b1, 56'h10_20_05_01_01_01_24, 1'b0);
      chk("R9", "holdoff after abort", {7'd0, holdoff_o}, 8'h00);
      idle(6);
      chk_all("R9", 56'h10_20_05_01_01_01_24, 1'b0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule